// File: doc/BRIEF.md
# Host Reset Qualifier and Stretcher

This block takes an asynchronous, active-low reset request from a host and turns it into a clean pair of reset outputs for the local card: an active-low local reset and an active-high reset. A request is honoured only if the host line falls from high to low and then stays low for a programmable number of clock cycles. Shorter dips are treated as noise and dropped.

Once a request is accepted, both outputs turn active together. They stay active for at least a programmable minimum number of cycles. If the host is still holding its line low when that minimum runs out, the outputs stay active until the host lets go. A new falling edge that arrives during this period does not restart the minimum timer.

A sticky "timer expired" flag tells the power controller when a reset sequence has finished. The flag rises when the outputs are released. It is cleared by the next accepted request or by a one-cycle power-off request. The host line passes through a two-flop synchroniser before edge detection. Both time thresholds are cycle-count parameters of a single system clock.

Top module: `host_rst_stretch`

## Requirements
- R1: While the system reset `rst_n` is low, and directly after it is released, `loc_rst_n` is 1, `rst_o` is 0 and `tmr_done` is 0.
- R2: `rst_o` is at all times the logical inverse of `loc_rst_n`.
- R3: A high-to-low transition of `host_rst_n` that stays low for fewer than QUAL_CYC clock edges has no effect on `loc_rst_n`, `rst_o` or `tmr_done`. One that stays low for QUAL_CYC edges or more is accepted. If the line is first low at clock edge 1, the outputs turn active right after edge QUAL_CYC+2.
- R4: Once active, the outputs stay active for at least HOLD_CYC clock cycles.
- R5: For a single accepted low pulse of L edges, the outputs stay active for max(HOLD_CYC, L-QUAL_CYC+1) cycles. They are released only after a high level of `host_rst_n` has passed the synchroniser.
- R6: A further falling edge of `host_rst_n` while the outputs are active does not restart the minimum period.
- R7: `tmr_done` goes to 1 in the same cycle that the outputs are released. It is 0 in the first cycle that the outputs are active after an accepted request.
- R8: A one-cycle high pulse on `pwr_off` clears `tmr_done` to 0. A rejected short pulse on `host_rst_n` leaves `tmr_done` unchanged.
- R9: If `host_rst_n` is already low when `rst_n` is released, no reset sequence starts until the line has gone high and fallen again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| host_rst_n | input | 1 | Asynchronous active-low reset request from the host |
| pwr_off | input | 1 | Power-off request; clears the expired flag |
| loc_rst_n | output | 1 | Active-low local reset |
| rst_o | output | 1 | Active-high reset |
| tmr_done | output | 1 | Sticky flag: last reset sequence has finished |

## Verification
The bench sweeps a single host low pulse over every length from one cycle up to well past QUAL_CYC+HOLD_CYC. The short lengths separate rejected pulses from accepted ones at the qualification boundary. The long lengths separate release at the minimum period from release that follows the host, with the crossover at exactly L = QUAL_CYC+HOLD_CYC. A two-pulse pattern, with the second falling edge inside the hold window, tells a timer that keeps running apart from one that restarts. A line already held low at reset release shows that only a real transition triggers. Glitch and power-off stimulus around a finished sequence show which events do and do not touch the expired flag.

// File: rtl/host_rst_stretch.sv
module host_rst_stretch #(
  parameter int unsigned QUAL_CYC = 8,
  parameter int unsigned HOLD_CYC = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic host_rst_n,
  input  logic pwr_off,
  output logic loc_rst_n,
  output logic rst_o,
  output logic tmr_done
);

  localparam int unsigned MAXC = (QUAL_CYC > HOLD_CYC) ? QUAL_CYC : HOLD_CYC;
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] QLIM = CW'(QUAL_CYC - 1);
  localparam logic [CW-1:0] HLIM = CW'(HOLD_CYC);

  typedef enum logic [1:0] {ST_IDLE, ST_QUAL, ST_HOLD, ST_EXT} st_t;

  st_t           st;
  logic [2:0]    sh;
  logic [CW-1:0] cnt;
  logic          done_q;

  wire lo   = ~sh[1];
  wire fall = sh[2] & ~sh[1];
  wire act  = (st == ST_HOLD) || (st == ST_EXT);

  assign loc_rst_n = ~act;
  assign rst_o     = act;
  assign tmr_done  = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      sh     <= '0;
      cnt    <= '0;
      done_q <= 1'b0;
    end else begin
      sh <= {sh[1:0], host_rst_n};
      if (pwr_off) done_q <= 1'b0;
      case (st)
        ST_IDLE: if (fall) begin
          st  <= ST_QUAL;
          cnt <= CW'(1);
        end
        ST_QUAL: begin
          if (!lo) st <= ST_IDLE;
          else if (cnt >= QLIM) begin
            st     <= ST_HOLD;
            cnt    <= CW'(1);
            done_q <= 1'b0;
          end else cnt <= cnt + CW'(1);
        end
        ST_HOLD: begin
          if (cnt >= HLIM) begin
            if (lo) st <= ST_EXT;
            else begin
              st     <= ST_IDLE;
              done_q <= 1'b1;
            end
          end else cnt <= cnt + CW'(1);
        end
        ST_EXT: if (!lo) begin
          st     <= ST_IDLE;
          done_q <= 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  initial begin
    if (QUAL_CYC < 2) $error("QUAL_CYC must be at least 2");
    if (HOLD_CYC < 1) $error("HOLD_CYC must be at least 1");
  end

endmodule

// File: rtl/host_rst_stretch_chk.sv
module host_rst_stretch_chk #(
  parameter int unsigned HOLD_CYC = 2000
) (
  input logic clk,
  input logic rst_n,
  input logic host_rst_n,
  input logic loc_rst_n,
  input logic rst_o,
  input logic tmr_done
);

  logic [31:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_len <= '0;
    else if (loc_rst_n) run_len <= '0;
    else if (run_len != 32'hFFFF_FFFF) run_len <= run_len + 32'd1;
  end

  a_r2_complement: assert property (@(posedge clk) disable iff (!rst_n)
    rst_o == !loc_rst_n);

  a_r3_assert_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(loc_rst_n) |-> !$past(host_rst_n, 3));

  a_r4_min_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loc_rst_n) |-> (run_len >= HOLD_CYC));

  a_r5_release_host_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loc_rst_n) |-> $past(host_rst_n, 3));

  a_r7_done_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loc_rst_n) |-> tmr_done);

  a_r7_done_clear_on_assert: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(loc_rst_n) |-> !tmr_done);

endmodule

bind host_rst_stretch host_rst_stretch_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_rst_n(host_rst_n),
  .loc_rst_n(loc_rst_n), .rst_o(rst_o), .tmr_done(tmr_done)
);

// File: tb/sim_host_rst_stretch.sv
`timescale 1ns/1ps
module sim_host_rst_stretch;
  localparam int Q = 3;
  localparam int H = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_n = 1'b1;
  logic pwr_off = 1'b0;
  logic loc_rst_n, rst_o, tmr_done;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  host_rst_stretch #(.QUAL_CYC(Q), .HOLD_CYC(H)) u0 (
    .clk(clk), .rst_n(rst_n), .host_rst_n(host_n), .pwr_off(pwr_off),
    .loc_rst_n(loc_rst_n), .rst_o(rst_o), .tmr_done(tmr_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit low_at(input int i, input int a1, input int b1, input int a2, input int b2);
    return (i >= a1 && i <= b1) || (i >= a2 && i <= b2);
  endfunction

  // host is low at posedge i when i lies in [a1,b1] or [a2,b2]
  task automatic run_pat(input int a1, input int b1, input int a2, input int b2, input int n,
                         output int first, output int cnt, output int bad, output int done_first);
    first = 0; cnt = 0; bad = 0; done_first = -1;
    @(negedge clk);
    host_n = !low_at(1, a1, b1, a2, b2);
    for (int i = 1; i <= n; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (rst_o != !loc_rst_n) bad++;
      if (!loc_rst_n) begin
        cnt++;
        if (first == 0) begin
          first = i;
          done_first = tmr_done;
        end
      end
      host_n = !low_at(i + 1, a1, b1, a2, b2);
    end
    host_n = 1'b1;
  endtask

  initial begin
    int first, cnt, bad, dfirst, exp_cnt, done_before, hit;
    // R9: host line low across reset release
    host_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(loc_rst_n == 1'b1 && rst_o == 1'b0 && tmr_done == 1'b0, "R1 in reset", loc_rst_n, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(loc_rst_n == 1'b1 && rst_o == 1'b0 && tmr_done == 1'b0, "R1 after reset", tmr_done, 0);
    hit = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (!loc_rst_n) hit++;
    end
    chk(hit == 0, "R9 low at reset release", hit, 0);
    host_n = 1'b1;
    repeat (6) @(negedge clk);

    // R3/R4/R5 sweep of single pulse lengths
    for (int L = 1; L <= 18; L++) begin
      done_before = tmr_done;
      run_pat(1, L, 0, -1, L + Q + H + 8, first, cnt, bad, dfirst);
      chk(bad == 0, "R2 complement", bad, 0);
      if (L < Q) begin
        chk(cnt == 0, "R3 short pulse ignored", cnt, 0);
        chk(tmr_done == done_before, "R8 short pulse keeps flag", tmr_done, done_before);
      end else begin
        exp_cnt = (L - Q + 1 > H) ? L - Q + 1 : H;
        chk(first == Q + 2, "R3 assert latency", first, Q + 2);
        chk(cnt >= H, "R4 minimum hold", cnt, H);
        chk(cnt == exp_cnt, "R5 active length", cnt, exp_cnt);
        chk(dfirst == 0, "R7 flag low at assert", dfirst, 0);
        chk(tmr_done == 1'b1, "R7 flag set at release", tmr_done, 1);
      end
      repeat (4) @(negedge clk);
    end

    // R6: second falling edge inside the hold window
    run_pat(1, 3, 6, 8, Q + H + 12, first, cnt, bad, dfirst);
    chk(first == Q + 2, "R6 first assert", first, Q + 2);
    chk(cnt == H, "R6 no restart", cnt, H);
    chk(bad == 0, "R2 complement two pulses", bad, 0);
    repeat (4) @(negedge clk);

    // R8: glitch keeps flag, pwr_off clears it
    run_pat(1, Q - 1, 0, -1, Q + 6, first, cnt, bad, dfirst);
    chk(tmr_done == 1'b1, "R8 glitch keeps flag set", tmr_done, 1);
    chk(cnt == 0, "R3 glitch ignored", cnt, 0);
    @(negedge clk);
    pwr_off = 1'b1;
    @(negedge clk);
    pwr_off = 1'b0;
    chk(tmr_done == 1'b0, "R8 pwr_off clears flag", tmr_done, 0);
    chk(loc_rst_n == 1'b1, "R8 pwr_off leaves outputs", loc_rst_n, 1);
    run_pat(1, Q, 0, -1, Q + H + 8, first, cnt, bad, dfirst);
    chk(cnt == H, "R4 hold after pwr_off", cnt, H);
    chk(tmr_done == 1'b1, "R7 flag set again", tmr_done, 1);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule